// File: doc/BRIEF.md
# Limit-Based Write-Allocate Qualifier

This block decides, for every write that has missed the first-level data cache, whether the line may be fetched and allocated on the write. It holds a 64-bit write-handling control word that is loaded through a single-cycle register-write port. The word carries an upper bound in 4 MB steps and a hole-enable bit. A write miss may allocate only if its address lies below the bound. A miss in the 15–16 MB area is also refused unless the hole-enable bit is set. The 640 KB–1 MB legacy display and firmware window is always refused.

Two layouts of the control word exist, and a static parameter picks one. The narrow layout has a 7-bit bound. The wide layout has a 10-bit bound and also obeys a memory-type flag that marks write-combining or uncacheable regions. The limit decision is combined with two allocation hints supplied by other mechanisms, the cacheable-page hint and the sector hint. Either hint allocates the line on its own. The decision is registered and appears one cycle after the request.

Top module: `wa_limit_qual`

## Requirements
- R1: After a synchronous active-low reset the control word is all zero, `dec_valid` and `dec_alloc` are 0, and a request with both hints low is not allocated.
- R2: `dec_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. `dec_alloc` is 0 whenever `dec_valid` is 0.
- R3: With both hints low and no exclusion active, a request allocates when `req_addr[31:22]` is below the bound field, that is when the address is below bound × 4 MB. It does not allocate at or above that address.
- R4: A bound field of zero disables the limit mechanism: no request with both hints low allocates.
- R5: With LAYOUT = LAYOUT_NARROW the bound sits in bits 7:1 of the written word and the hole-enable bit in bit 0. Bit 8 and every other bit have no effect. The largest bound, 127, allows addresses up to 508 MB − 1.
- R6: With LAYOUT = LAYOUT_WIDE the bound sits in bits 31:22 and the hole-enable bit in bit 16. All other bits have no effect. The largest bound, 1023, allows addresses up to 4092 MB − 1.
- R7: Addresses 0x00F0_0000 to 0x00FF_FFFF allocate through the limit mechanism only when the hole-enable bit is 1. When the bound is below 4 (16 MB), those addresses lie above the bound and the hole-enable bit changes nothing.
- R8: Addresses 0x000A_0000 to 0x000F_FFFF never allocate through the limit mechanism. 0x0009_FFFF and 0x0010_0000 are not excluded by this rule.
- R9: With the wide layout, `req_mtype_nc` high blocks the limit mechanism. With the narrow layout, `req_mtype_nc` has no effect.
- R10: `req_page_hint` or `req_sector_hint` high makes the request allocate, whatever the bound, the hole, the legacy window or the memory-type flag.
- R11: The control word changes only on a cycle with `cfg_we` high. A request in the same cycle as a write is decided with the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the control word this cycle |
| cfg_wdata | input | 64 | Value written to the control word |
| req_valid | input | 1 | A write miss is presented this cycle |
| req_addr | input | 32 | Byte address of the write miss |
| req_mtype_nc | input | 1 | Region is write-combining or uncacheable (wide layout only) |
| req_page_hint | input | 1 | Cacheable-page mechanism requests allocation |
| req_sector_hint | input | 1 | Sector mechanism requests allocation |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_alloc | output | 1 | The decided request may be write-allocated |

## Verification
The bench puts a narrow-layout and a wide-layout instance side by side and probes the exact edges of each region: the last word below the bound and the first word at it, both ends of the 15–16 MB hole and of the legacy window, and the largest bound of each layout. A compare that is off by one, or a bound taken from the wrong bit field, would allocate the first address at the bound or refuse the last one below it. A hole that ignored its enable bit, or that still refused when the bound was under 16 MB, shows up at 0x00F0_0000. Further probes show that the memory-type flag leaks into the narrow layout, that a hint fails to override an exclusion, or that a request made in the same cycle as a register write sees the new value.

// File: rtl/wa_qual_pkg.sv
// Package: shared types and field positions for the write-allocate qualifier.
// Assumes a 32-bit byte address and a 4 MB bound granule.
package wa_qual_pkg;

    typedef enum logic {
        LAYOUT_NARROW = 1'b0,
        LAYOUT_WIDE   = 1'b1
    } wa_layout_e;

    localparam int WA_ADDR_W     = 32;
    localparam int WA_REG_W      = 64;
    localparam int WA_GRAN_SHIFT = 22;                          // 4 MB granule
    localparam int WA_LIM_W      = WA_ADDR_W - WA_GRAN_SHIFT;   // 10

    // Field positions for each layout
    localparam int NARROW_LIM_LSB  = 1;
    localparam int NARROW_LIM_W    = 7;
    localparam int NARROW_HOLE_BIT = 0;
    localparam int WIDE_LIM_LSB    = 22;
    localparam int WIDE_LIM_W      = 10;
    localparam int WIDE_HOLE_BIT   = 16;

    // Region decode in 1 MB units (address bits 31:20)
    localparam int MB_W              = WA_ADDR_W - 20;
    localparam logic [MB_W-1:0] HOLE_MB = MB_W'(15);
    // Legacy window in 64 KB units inside the first megabyte (bits 19:16)
    localparam logic [3:0] LEGACY_LO_64K = 4'hA;

    typedef struct packed {
        logic [WA_LIM_W-1:0] limit;
        logic                hole_en;
    } wa_fields_t;

endpackage

// File: rtl/wa_ctrl_reg.sv
// Module: wa_ctrl_reg
// Holds the fields of the write-handling control word. Only the bound and the
// hole-enable bit are kept; every other bit of a write is discarded. The
// LAYOUT parameter picks which bit fields of the written word are used.
// Assumes a synchronous active-low reset.
module wa_ctrl_reg
    import wa_qual_pkg::*;
#(
    parameter wa_layout_e LAYOUT = LAYOUT_WIDE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WA_REG_W-1:0] wr_data,
    output wa_fields_t          fields
);

    wa_fields_t fields_d;
    wa_fields_t fields_q;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Extract the fields from the written word for the selected layout
    generate
        if (LAYOUT == LAYOUT_NARROW) begin : g_narrow
            always_comb begin
                fields_d.limit   = WA_LIM_W'(wr_data[NARROW_LIM_LSB +: NARROW_LIM_W]);
                fields_d.hole_en = wr_data[NARROW_HOLE_BIT];
            end
        end else begin : g_wide
            always_comb begin
                fields_d.limit   = WA_LIM_W'(wr_data[WIDE_LIM_LSB +: WIDE_LIM_W]);
                fields_d.hole_en = wr_data[WIDE_HOLE_BIT];
            end
        end
    endgenerate

    // Control word storage: cleared on reset, loaded on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= fields_d;
        end
    end

    assign fields = fields_q;

    // R11: without a write strobe the stored fields do not move
    assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields_q));

endmodule

// File: rtl/wa_range_check.sv
// Module: wa_range_check
// Combinational limit mechanism: below-bound compare, conditional 15-16 MB
// hole, fixed legacy window and (wide layout only) memory-type block.
// Assumes the fields come from wa_ctrl_reg. The hole needs no explicit bound
// test: when the bound is under 16 MB the hole lies above it anyway.
module wa_range_check
    import wa_qual_pkg::*;
#(
    parameter wa_layout_e LAYOUT = LAYOUT_WIDE
) (
    input  wa_fields_t           fields,
    input  logic [WA_ADDR_W-1:0] addr,
    input  logic                 mtype_nc,
    output logic                 lim_ok
);

    logic below_bound;
    logic in_hole;
    logic in_legacy;
    logic mt_block;

    // Region decode of the request address
    always_comb begin
        below_bound = addr[WA_ADDR_W-1:WA_GRAN_SHIFT] < fields.limit;
        in_hole     = addr[WA_ADDR_W-1:20] == HOLE_MB;
        in_legacy   = (addr[WA_ADDR_W-1:20] == '0) && (addr[19:16] >= LEGACY_LO_64K);
    end

    // Memory-type block exists only in the wide layout
    generate
        if (LAYOUT == LAYOUT_WIDE) begin : g_mt
            assign mt_block = mtype_nc;
        end else begin : g_no_mt
            logic unused_mtype;
            assign unused_mtype = mtype_nc;
            assign mt_block     = 1'b0;
        end
    endgenerate

    // Final limit-mechanism verdict
    always_comb begin
        lim_ok = below_bound && !(in_hole && !fields.hole_en) && !in_legacy && !mt_block;
    end

endmodule

// File: rtl/wa_limit_qual.sv
// Module: wa_limit_qual (top)
// Decides write allocation for each first-level write miss. Combines the
// limit mechanism with the cacheable-page and sector hints and registers
// the verdict so that it appears one cycle after req_valid.
// Assumes a synchronous active-low reset and a 32-bit byte address.
module wa_limit_qual
    import wa_qual_pkg::*;
#(
    parameter wa_layout_e LAYOUT = LAYOUT_WIDE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [WA_REG_W-1:0]   cfg_wdata,
    input  logic                  req_valid,
    input  logic [WA_ADDR_W-1:0]  req_addr,
    input  logic                  req_mtype_nc,
    input  logic                  req_page_hint,
    input  logic                  req_sector_hint,
    output logic                  dec_valid,
    output logic                  dec_alloc
);

    wa_fields_t fields;
    logic       lim_ok;
    logic       any_hint;

    wa_ctrl_reg #(.LAYOUT(LAYOUT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .fields  (fields)
    );

    wa_range_check #(.LAYOUT(LAYOUT)) u_range (
        .fields   (fields),
        .addr     (req_addr),
        .mtype_nc (req_mtype_nc),
        .lim_ok   (lim_ok)
    );

    assign any_hint = req_page_hint || req_sector_hint;

    // Decision register: one verdict per request, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_alloc <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            dec_alloc <= req_valid && (lim_ok || any_hint);
        end
    end

    // R2: a verdict follows every request by one cycle
    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    // R2: no request, no verdict and no allocation
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_alloc));

    // R10: either hint forces allocation
    assert_hint_forces_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hint) |=> dec_alloc);

    // R4: a zero bound never allocates without a hint
    assert_zero_bound_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_hint && fields.limit == '0) |=> !dec_alloc);

    // R8: the legacy window never allocates without a hint
    assert_legacy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_hint && req_addr >= 32'h000A_0000 && req_addr <= 32'h000F_FFFF)
        |=> !dec_alloc);

endmodule

// File: tb/wa_limit_qual_tb.sv
`timescale 1ns/1ps
module wa_limit_qual_tb;
    import wa_qual_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [63:0] wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        mt = 1'b0, pg = 1'b0, sc = 1'b0;
    logic        dv_a, da_a, dv_b, da_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wa_limit_qual #(.LAYOUT(LAYOUT_NARROW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_wdata(wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_mtype_nc(mt),
        .req_page_hint(pg), .req_sector_hint(sc),
        .dec_valid(dv_a), .dec_alloc(da_a));

    wa_limit_qual #(.LAYOUT(LAYOUT_WIDE)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_b), .cfg_wdata(wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_mtype_nc(mt),
        .req_page_hint(pg), .req_sector_hint(sc),
        .dec_valid(dv_b), .dec_alloc(da_b));

    function automatic logic [63:0] enc_a(input logic [6:0] lim, input logic hole, input logic b8);
        return {55'd0, b8, lim, hole};
    endfunction

    function automatic logic [63:0] enc_b(input logic [9:0] lim, input logic hole);
        logic [63:0] v = '0;
        v[31:22] = lim;
        v[16]    = hole;
        return v;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr_a(input logic [63:0] v);
        @(negedge clk); wdata = v; we_a = 1'b1;
        @(negedge clk); we_a = 1'b0;
    endtask

    task automatic wr_b(input logic [63:0] v);
        @(negedge clk); wdata = v; we_b = 1'b1;
        @(negedge clk); we_b = 1'b0;
    endtask

    // Present one request; verdict is sampled at the next falling edge
    task automatic ask(input logic [31:0] a, input logic m, input logic p, input logic s,
                       input logic ea, input logic eb, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; mt = m; pg = p; sc = s;
        @(negedge clk);
        req_valid = 1'b0; mt = 1'b0; pg = 1'b0; sc = 1'b0;
        chk({tag, " valid A (R2)"}, dv_a, 1'b1);
        chk({tag, " valid B (R2)"}, dv_b, 1'b1);
        chk({tag, " alloc A"}, da_a, ea);
        chk({tag, " alloc B"}, db_dummy(da_b), eb);
    endtask

    function automatic logic db_dummy(input logic v);
        return v;
    endfunction

    task automatic t_reset();
        chk("R1 reset valid A", dv_a, 1'b0);
        chk("R1 reset valid B", dv_b, 1'b0);
        chk("R1 reset alloc A", da_a, 1'b0);
        ask(32'h0000_1000, 0, 0, 0, 0, 0, "R1 request after reset");
    endtask

    task automatic t_timing();
        @(negedge clk);
        chk("R2 idle valid A", dv_a, 1'b0);
        chk("R2 idle alloc B", da_b, 1'b0);
        ask(32'h0000_0000, 0, 1, 0, 1, 1, "R2 single request");
        @(negedge clk);
        chk("R2 valid drops A", dv_a, 1'b0);
        chk("R2 valid drops B", dv_b, 1'b0);
    endtask

    task automatic t_bound();
        wr_a(enc_a(7'd8, 1'b0, 1'b0));
        wr_b(enc_b(10'd16, 1'b1));
        ask(32'h01FF_FFFC, 0, 0, 0, 1, 1, "R3 below 32MB");
        ask(32'h0200_0000, 0, 0, 0, 0, 1, "R3 at 32MB");
        ask(32'h03FF_FFFF, 0, 0, 0, 0, 1, "R3 below 64MB");
        ask(32'h0400_0000, 0, 0, 0, 0, 0, "R3 at 64MB");
    endtask

    task automatic t_max();
        wr_a(enc_a(7'd127, 1'b1, 1'b0));
        wr_b(enc_b(10'd1023, 1'b1));
        ask(32'h1FBF_FFFF, 0, 0, 0, 1, 1, "R5 narrow max last");
        ask(32'h1FC0_0000, 0, 0, 0, 0, 1, "R5 narrow max at bound");
        ask(32'hFFBF_FFFF, 0, 0, 0, 0, 1, "R6 wide max last");
        ask(32'hFFC0_0000, 0, 0, 0, 0, 0, "R6 wide max at bound");
        // R6: bits outside 31:22 and 16 have no effect
        wr_b(enc_b(10'd8, 1'b0) | 64'hFFFF_FFFF_003E_FFFF);
        ask(32'h01FF_FFFC, 0, 0, 0, 1, 1, "R6 stray bits in");
        ask(32'h0200_0000, 0, 0, 0, 1, 0, "R6 stray bits out");
    endtask

    task automatic t_zero();
        wr_a(enc_a(7'd0, 1'b1, 1'b0));
        wr_b(enc_b(10'd0, 1'b1));
        ask(32'h0010_0000, 0, 0, 0, 0, 0, "R4 zero bound");
        ask(32'h0000_0040, 0, 0, 0, 0, 0, "R4 zero bound low");
    endtask

    task automatic t_bit8();
        wr_a(enc_a(7'd8, 1'b0, 1'b1) | 64'hFFFF_FFFF_FFFF_FE00);
        ask(32'h0100_0000, 0, 0, 0, 1, 0, "R5 bit8 set inside");
        ask(32'h0200_0000, 0, 0, 0, 0, 0, "R5 bit8 set outside");
    endtask

    task automatic t_hole();
        wr_a(enc_a(7'd8, 1'b0, 1'b0));
        wr_b(enc_b(10'd4, 1'b0));
        ask(32'h00EF_FFFF, 0, 0, 0, 1, 1, "R7 below hole");
        ask(32'h00F0_0000, 0, 0, 0, 0, 0, "R7 hole start closed");
        ask(32'h00FF_FFFF, 0, 0, 0, 0, 0, "R7 hole end closed");
        ask(32'h0100_0000, 0, 0, 0, 1, 0, "R7 above hole");
        wr_a(enc_a(7'd8, 1'b1, 1'b0));
        wr_b(enc_b(10'd4, 1'b1));
        ask(32'h00F0_0000, 0, 0, 0, 1, 1, "R7 hole open");
        wr_a(enc_a(7'd3, 1'b1, 1'b0));
        ask(32'h00F0_0000, 0, 0, 0, 0, 1, "R7 bound under 16MB");
        ask(32'h00BF_FFFF, 0, 0, 0, 1, 1, "R7 bound 12MB last");
    endtask

    task automatic t_legacy();
        wr_a(enc_a(7'd8, 1'b1, 1'b0));
        wr_b(enc_b(10'd8, 1'b1));
        ask(32'h0009_FFFF, 0, 0, 0, 1, 1, "R8 just below window");
        ask(32'h000A_0000, 0, 0, 0, 0, 0, "R8 window start");
        ask(32'h000F_FFFF, 0, 0, 0, 0, 0, "R8 window end");
        ask(32'h0010_0000, 0, 0, 0, 1, 1, "R8 just above window");
    endtask

    task automatic t_mtype();
        ask(32'h0020_0000, 1, 0, 0, 1, 0, "R9 memory-type flag");
        ask(32'h0020_0000, 0, 0, 0, 1, 1, "R9 flag clear");
    endtask

    task automatic t_hints();
        ask(32'h000B_0000, 0, 1, 0, 1, 1, "R10 page hint in window");
        ask(32'h0020_0000, 1, 0, 1, 1, 1, "R10 sector hint with mtype");
        wr_a(enc_a(7'd0, 1'b0, 1'b0));
        wr_b(enc_b(10'd0, 1'b0));
        ask(32'h8000_0000, 0, 0, 1, 1, 1, "R10 sector hint zero bound");
        ask(32'h00F0_0000, 0, 1, 1, 1, 1, "R10 both hints in hole");
    endtask

    task automatic t_same_cycle();
        wr_a(enc_a(7'd8, 1'b1, 1'b0));
        wr_b(enc_b(10'd8, 1'b1));
        @(negedge clk);
        wdata = '0; we_a = 1'b1; we_b = 1'b1;
        req_valid = 1'b1; req_addr = 32'h0020_0000;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0; req_valid = 1'b0;
        chk("R11 same-cycle old value A", da_a, 1'b1);
        chk("R11 same-cycle old value B", da_b, 1'b1);
        ask(32'h0020_0000, 0, 0, 0, 0, 0, "R11 next request new value");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_bound();
        t_max();
        t_zero();
        t_bit8();
        t_hole();
        t_legacy();
        t_mtype();
        t_hints();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule